// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes one word at a time from a transmit valid/ready stream, shifts it out on MOSI while generating SCLK, assembles the bits seen on MISO into a word, and offers that word on a receive valid/ready stream. The serial clock rate comes from a 16-bit baud value. Clock polarity, sampling edge, word length (1 to 32 bits), bit order and an internal loopback path are all selectable. The transmit side and the receive side can each be switched off on their own. When the transmit side is off the engine clocks receive-only words by itself, and MOSI holds a programmable idle level.

Configuration inputs are latched when a word is loaded and are meant to change only while the engine is idle. A word is loaded on the same edge that ends the previous one, so a stream of transmit words leaves the wire with no idle cycle between words. If a received word is finished while the receive holding stage is still occupied, the engine parks with SCLK at its idle level until the consumer takes the held word.

The controller is built around four states. S_IDLE waits for work. S_HALF_A is the first half of a bit cell, and the receive sample is taken on its last cycle. S_HALF_B is the second half of a bit cell. S_STALL waits for space in the receive holding stage. The transitions are:
- S_IDLE goes to S_HALF_A on a load.
- S_HALF_A goes to S_HALF_B on a baud tick.
- S_HALF_B goes to S_HALF_A on a tick when bits remain.
- On a tick after the last bit, S_HALF_B goes to S_HALF_A if the next word loads, to S_IDLE if the word finishes with nothing to load, and to S_STALL if the receive holding stage is full.
- S_STALL goes to S_HALF_A or S_IDLE on `rx_ready`, depending on whether a new word loads.

Top module: `spi_shift_engine`

## Requirements
- R1: Each half of a bit cell lasts `baud_div`+1 module clocks, so the SCLK period is 2*(`baud_div`+1) clocks, and `baud_div`=0 gives the fastest rate.
- R2: `cfg_len_m1` holds the bits per word minus one, so a word has `cfg_len_m1`+1 bits. Transmit bits above that length are ignored, and an isolated word keeps the engine busy for exactly 2*(`cfg_len_m1`+1)*(`baud_div`+1) clocks.
- R3: SCLK idles at `cfg_cpol`. With `cfg_lead_sample`=1, the first half of each cell holds SCLK at the idle level, and data is sampled on the leading edge. With `cfg_lead_sample`=0, the first half holds SCLK at the active level, data changes on the leading edge, and data is sampled on the trailing edge.
- R4: With `cfg_msb_first`=1, bit `cfg_len_m1` is the first bit on the wire in both directions. With `cfg_msb_first`=0, bit 0 goes first.
- R5: With `cfg_loopback`=1, the received bits are the bits driven on MOSI and MISO is ignored.
- R6: With `cfg_tx_off`=1, `tx_ready` never rises and MOSI stays at the idle level. If the receiver is on, a receive-only word starts whenever the engine is idle and the holding stage is empty or being read.
- R7: With `cfg_rx_off`=1, received words are dropped and `rx_valid` does not rise.
- R8: A received word appears right-aligned on `rx_data` with all bits above the word length at zero. It is held stable with `rx_valid` high until `rx_ready` is seen.
- R9: After reset the engine is idle: `busy`, `tx_ready` and `rx_valid` are low. `busy` stays high from the load edge until the last half cell of the final word has ended.
- R10: If `tx_valid` is high when a word ends, `tx_ready` is high in that cycle and the next word starts on that same edge, with no idle cycle between words.
- R11: While idle, MOSI equals `cfg_idle_level` and SCLK equals `cfg_cpol`.
- R12: If a word ends while the holding stage is full and is not being read, the engine waits with `busy` high and SCLK at the idle level. The held word is not overwritten, and the new word is committed once `rx_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_m1 | input | 5 | Bits per word minus one |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_lead_sample | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_loopback | input | 1 | Feed MOSI back as the receive input |
| cfg_tx_off | input | 1 | Transmitter off, receive-only words |
| cfg_rx_off | input | 1 | Receiver off, drop received words |
| cfg_idle_level | input | 1 | MOSI level while no transmit data is driven |
| baud_div | input | 16 | Half-cell length minus one, in clocks |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken on this edge |
| tx_data | input | 32 | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes the held word |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is in flight or waiting to be committed |

## Verification
A bench slave follows SCLK, samples MOSI and drives MISO at the edges the polarity and phase settings call for. Its inputs are the full 8-bit pattern, a 16-bit back-to-back stream with the trailing-edge mode, a 32-bit word, and a 5-bit LSB-first word whose upper transmit bits are set. Each one separates errors in bit order, in the choice of sampling edge and in length masking, and timing the gap between sample edges at several baud values exposes divider errors. Loopback, receiver-off, transmitter-off and a full receive holding stage are each run on their own, so that a wrong data source, a leaked word, a consumed transmit word or an overwritten held word shows up in the words and flags at the ports.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_HALF_A = 2'd1,
        S_HALF_B = 2'd2,
        S_STALL  = 2'd3
    } eng_state_t;

    typedef struct packed {
        logic cpol;
        logic lead_sample;
        logic msb_first;
        logic loopback;
        logic tx_off;
        logic rx_off;
        logic idle_lvl;
    } eng_flags_t;

endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] limit,
    output logic              tick
);

    logic [BAUD_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_eng_txreg.sv
module spi_eng_txreg #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [LEN_W-1:0]  bit_idx,
    output logic              bit_out
);

    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_word;
        end
    end

    assign bit_out = word_q[bit_idx];

endmodule

// File: rtl/spi_eng_rxasm.sv
module spi_eng_rxasm #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              sample_bit,
    input  logic [LEN_W-1:0]  bit_idx,
    input  logic              commit,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);

    logic [DATA_W-1:0] asm_q;

    // assembly register: cleared per word so unused upper bits read zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else if (clear) begin
            asm_q <= '0;
        end else if (sample) begin
            asm_q[bit_idx] <= sample_bit;
        end
    end

    // one-word holding stage towards the consumer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else if (commit) begin
            rx_valid <= 1'b1;
            rx_data  <= asm_q;
        end else if (rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BAUD_W = 16,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic              cfg_cpol,
    input  logic              cfg_lead_sample,
    input  logic              cfg_msb_first,
    input  logic              cfg_loopback,
    input  logic              cfg_tx_off,
    input  logic              cfg_rx_off,
    input  logic              cfg_idle_level,
    input  logic [BAUD_W-1:0] baud_div,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);

    eng_state_t        state_q, state_d;
    eng_flags_t        flags_q;
    logic [LEN_W-1:0]  len_q;
    logic [BAUD_W-1:0] baud_q;
    logic [LEN_W-1:0]  bit_cnt_q;

    logic tick, run, last_bit, word_end, hold_free;
    logic finish, commit, load, tx_start, rxonly_start;
    logic [LEN_W-1:0] bit_idx;
    logic tx_bit, wire_bit, rx_in;

    // event decode
    assign run          = (state_q == S_HALF_A) || (state_q == S_HALF_B);
    assign last_bit     = (bit_cnt_q == len_q);
    assign word_end     = (state_q == S_HALF_B) && tick && last_bit;
    assign hold_free    = !rx_valid || rx_ready;
    assign finish       = (word_end && (flags_q.rx_off || hold_free))
                        || ((state_q == S_STALL) && rx_ready);
    assign commit       = (word_end && !flags_q.rx_off && hold_free)
                        || ((state_q == S_STALL) && rx_ready);
    assign tx_start     = !cfg_tx_off && tx_valid;
    assign rxonly_start = cfg_tx_off && !cfg_rx_off && hold_free;
    assign load         = ((state_q == S_IDLE) && (tx_start || rxonly_start))
                        || (finish && tx_start);
    assign tx_ready     = load && !cfg_tx_off;

    assign bit_idx  = flags_q.msb_first ? (len_q - bit_cnt_q) : bit_cnt_q;
    assign wire_bit = flags_q.tx_off ? flags_q.idle_lvl : tx_bit;
    assign rx_in    = flags_q.loopback ? wire_bit : miso;

    spi_eng_baud #(
        .BAUD_W (BAUD_W)
    ) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (baud_q),
        .tick  (tick)
    );

    spi_eng_txreg #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_txreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (tx_data),
        .bit_idx   (bit_idx),
        .bit_out   (tx_bit)
    );

    spi_eng_rxasm #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_rxasm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (load),
        .sample     ((state_q == S_HALF_A) && tick),
        .sample_bit (rx_in),
        .bit_idx    (bit_idx),
        .commit     (commit),
        .rx_ready   (rx_ready),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (load) state_d = S_HALF_A;
            end
            S_HALF_A: begin
                if (tick) state_d = S_HALF_B;
            end
            S_HALF_B: begin
                if (tick) begin
                    if (!last_bit)   state_d = S_HALF_A;
                    else if (load)   state_d = S_HALF_A;
                    else if (finish) state_d = S_IDLE;
                    else             state_d = S_STALL;
                end
            end
            S_STALL: begin
                if (rx_ready) state_d = load ? S_HALF_A : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and per-word context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            flags_q   <= '0;
            len_q     <= '0;
            baud_q    <= '0;
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                flags_q   <= '{cpol:        cfg_cpol,
                               lead_sample: cfg_lead_sample,
                               msb_first:   cfg_msb_first,
                               loopback:    cfg_loopback,
                               tx_off:      cfg_tx_off,
                               rx_off:      cfg_rx_off,
                               idle_lvl:    cfg_idle_level};
                len_q     <= cfg_len_m1;
                baud_q    <= baud_div;
                bit_cnt_q <= '0;
            end else if ((state_q == S_HALF_B) && tick && !last_bit) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // outputs per state
    always_comb begin
        busy = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE: begin
                sclk = cfg_cpol;
                mosi = cfg_idle_level;
            end
            S_HALF_A: begin
                sclk = flags_q.cpol ^ ~flags_q.lead_sample;
                mosi = wire_bit;
            end
            S_HALF_B: begin
                sclk = flags_q.cpol ^ flags_q.lead_sample;
                mosi = wire_bit;
            end
            S_STALL: begin
                sclk = flags_q.cpol;
                mosi = flags_q.idle_lvl;
            end
            default: begin
                sclk = cfg_cpol;
                mosi = cfg_idle_level;
            end
        endcase
    end

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_cpol,
    input logic              cfg_tx_off,
    input logic              cfg_rx_off,
    input logic              cfg_idle_level,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic              sclk,
    input logic              mosi,
    input logic              busy
);

    a_r11_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg_cpol));

    a_r11_idle_mosi: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mosi == cfg_idle_level));

    a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    a_r6_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tx_off |-> !tx_ready);

    a_r10_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_valid);

    a_r9_take_starts_word: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> busy);

    a_r7_rx_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rx_valid && cfg_rx_off) |=> !rx_valid);

endmodule

bind spi_shift_engine spi_shift_engine_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_cpol       (cfg_cpol),
    .cfg_tx_off     (cfg_tx_off),
    .cfg_rx_off     (cfg_rx_off),
    .cfg_idle_level (cfg_idle_level),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .rx_valid       (rx_valid),
    .rx_ready       (rx_ready),
    .rx_data        (rx_data),
    .sclk           (sclk),
    .mosi           (mosi),
    .busy           (busy)
);

// File: tb/tb_spi_shift_engine.sv
`timescale 1ns/1ps
module tb_spi_shift_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  len_m1 = 5'd7;
    logic        cpol = 1'b0, lead = 1'b1, msbf = 1'b1, lpbk = 1'b0;
    logic        txoff = 1'b0, rxoff = 1'b0, idle = 1'b0;
    logic [15:0] baud = 16'd1;
    logic        tx_valid = 1'b0, tx_ready;
    logic [31:0] tx_data = '0;
    logic        rx_valid, rx_ready = 1'b1;
    logic [31:0] rx_data;
    logic        sclk, mosi, miso = 1'b0, busy;

    always #2.5 clk = ~clk;

    spi_shift_engine dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_len_m1 (len_m1), .cfg_cpol (cpol), .cfg_lead_sample (lead),
        .cfg_msb_first (msbf), .cfg_loopback (lpbk), .cfg_tx_off (txoff),
        .cfg_rx_off (rxoff), .cfg_idle_level (idle), .baud_div (baud),
        .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_data (tx_data),
        .rx_valid (rx_valid), .rx_ready (rx_ready), .rx_data (rx_data),
        .sclk (sclk), .mosi (mosi), .miso (miso), .busy (busy)
    );

    int checks = 0, fails = 0;
    int cyc = 0, busy_cnt = 0, falls = 0;
    int sk = 0, last_edge = 0;
    logic prev_sclk = 1'b0, prev_busy = 1'b0;
    logic [31:0] sl_rx = '0;
    logic [31:0] exp_mosi[$];
    logic [31:0] sl_q[$];
    logic [31:0] exp_rx[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] msk(input logic [31:0] v, input int n);
        return (n >= 32) ? v : (v & ((32'h1 << n) - 32'h1));
    endfunction

    // watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // busy bookkeeping (R9, R10)
    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (prev_busy && !busy) falls++;
        prev_busy = busy;
        if (rst_n && txoff && tx_ready) chk(1'b0, "R6 tx_ready while transmitter off", 32'd1, 32'd0);
    end

    // bench slave: samples MOSI, drives MISO (R1, R3, R4)
    always @(negedge clk) begin
        automatic int n = int'(len_m1) + 1;
        automatic logic first_lvl = lead ? cpol : ~cpol;
        automatic int p;
        if (rst_n && busy && prev_sclk == first_lvl && sclk != first_lvl) begin
            p = msbf ? (n - 1 - sk) : sk;
            sl_rx[p] = mosi;
            if (sk > 0)
                chk((cyc - last_edge) == 2 * (int'(baud) + 1), "R1 sample spacing",
                    32'(cyc - last_edge), 32'(2 * (int'(baud) + 1)));
            last_edge = cyc;
            sk++;
            if (sk == n) begin
                if (exp_mosi.size() == 0) chk(1'b0, "R4 unexpected MOSI word", sl_rx, 32'h0);
                else begin
                    automatic logic [31:0] e = exp_mosi.pop_front();
                    chk(sl_rx == e, "R4 MOSI word", sl_rx, e);
                end
                if (sl_q.size() != 0) void'(sl_q.pop_front());
                sk = 0;
                sl_rx = '0;
            end
        end
        if (sclk == first_lvl) begin
            p = msbf ? (n - 1 - sk) : sk;
            miso = (sl_q.size() != 0) ? sl_q[0][p] : 1'b0;
        end
        prev_sclk = sclk;
    end

    // receive monitor (R5, R7, R8)
    always @(negedge clk) begin
        if (rst_n && rx_valid && rx_ready) begin
            if (exp_rx.size() == 0) chk(1'b0, "R7 unexpected received word", rx_data, 32'h0);
            else begin
                automatic logic [31:0] e = exp_rx.pop_front();
                chk(rx_data == e, "R8 received word", rx_data, e);
            end
        end
    end

    task automatic setcfg(input logic [4:0] l, input logic po, input logic ls, input logic mf,
                          input logic lb, input logic to, input logic ro, input logic il,
                          input logic [15:0] b);
        len_m1 = l; cpol = po; lead = ls; msbf = mf; lpbk = lb;
        txoff = to; rxoff = ro; idle = il; baud = b;
        sk = 0; sl_rx = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] tw, input logic [31:0] sw);
        automatic int n = int'(len_m1) + 1;
        exp_mosi.push_back(msk(tw, n));
        sl_q.push_back(sw);
        if (!rxoff) exp_rx.push_back(lpbk ? msk(tw, n) : msk(sw, n));
        tx_valid = 1'b1;
        tx_data  = tw;
        #1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || exp_mosi.size() != 0 || exp_rx.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R9, R11)
        chk(busy == 1'b0, "R9 busy after reset", 32'(busy), 32'd0);
        chk(tx_ready == 1'b0 && rx_valid == 1'b0, "R9 handshakes after reset", {tx_ready, rx_valid}, 32'd0);
        chk(sclk == 1'b0 && mosi == 1'b0, "R11 idle lines after reset", {sclk, mosi}, 32'd0);

        // 8-bit, leading-edge sampling, MSB first (R3, R4, R9)
        setcfg(5'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1);
        busy_cnt = 0;
        send(32'h0000_00A5, 32'h0000_003C);
        wait_idle();
        chk(busy_cnt == 32, "R9 busy length 8-bit word", 32'(busy_cnt), 32'd32);

        // 16-bit back-to-back stream, trailing-edge sampling, LSB first, cpol 1 (R10)
        setcfg(5'd15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
        busy_cnt = 0; falls = 0;
        send(32'h0000_1234, 32'h0000_BEEF);
        send(32'h0000_8001, 32'h0000_7FFE);
        send(32'h0000_F00D, 32'h0000_0F0F);
        wait_idle();
        chk(busy_cnt == 96, "R10 gapless busy cycles", 32'(busy_cnt), 32'd96);
        chk(falls == 1, "R10 busy fell once", 32'(falls), 32'd1);

        // 32-bit word (R2, R3)
        setcfg(5'd31, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd2);
        send(32'hDEAD_BEEF, 32'h1234_5678);
        wait_idle();

        // 5-bit LSB first with garbage in upper transmit bits (R2)
        setcfg(5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd5);
        busy_cnt = 0;
        send(32'hFFFF_FFE9, 32'hFFFF_FF16);
        wait_idle();
        chk(busy_cnt == 60, "R2 busy length 5-bit word", 32'(busy_cnt), 32'd60);

        // loopback (R5)
        setcfg(5'd11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1);
        send(32'h0000_0ABC, 32'h0000_0555);
        wait_idle();

        // receiver off (R7)
        setcfg(5'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd0);
        send(32'h0000_0011, 32'h0000_0022);
        send(32'h0000_0033, 32'h0000_0044);
        wait_idle();
        chk(rx_valid == 1'b0, "R7 nothing held with receiver off", 32'(rx_valid), 32'd0);

        // transmitter off: receive-only words, MOSI at idle level (R6)
        rx_ready = 1'b0;
        setcfg(5'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'd1);
        exp_mosi.push_back(32'h0000_00FF); sl_q.push_back(32'h0000_005A); exp_rx.push_back(32'h0000_005A);
        exp_mosi.push_back(32'h0000_00FF); sl_q.push_back(32'h0000_00C3); exp_rx.push_back(32'h0000_00C3);
        tx_valid = 1'b1; tx_data = 32'h0000_0077;
        txoff = 1'b1;
        do @(negedge clk); while (!rx_valid);
        chk(tx_ready == 1'b0, "R6 transmit word not taken", 32'(tx_ready), 32'd0);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        do @(negedge clk); while (!rx_valid);
        tx_valid = 1'b0;
        txoff = 1'b0;
        rx_ready = 1'b1;
        wait_idle();
        chk(mosi == 1'b1, "R11 idle MOSI high", 32'(mosi), 32'd1);
        idle = 1'b0;
        @(negedge clk);
        chk(mosi == 1'b0, "R11 idle MOSI low", 32'(mosi), 32'd0);

        // full holding stage stalls the engine (R12)
        setcfg(5'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1);
        rx_ready = 1'b0;
        send(32'h0000_0081, 32'h0000_0096);
        send(32'h0000_0042, 32'h0000_0069);
        repeat (50) @(negedge clk);
        chk(busy == 1'b1, "R12 busy while stalled", 32'(busy), 32'd1);
        chk(sclk == cpol, "R12 SCLK idle while stalled", 32'(sclk), 32'(cpol));
        chk(rx_valid == 1'b1 && rx_data == 32'h0000_0096, "R12 first word kept", rx_data, 32'h0000_0096);
        rx_ready = 1'b1;
        wait_idle();

        chk(exp_rx.size() == 0, "R8 all received words seen", 32'(exp_rx.size()), 32'd0);
        chk(exp_mosi.size() == 0, "R4 all MOSI words seen", 32'(exp_mosi.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule